// File: doc/BRIEF.md
# Receiver Reset and Recovery Sequencer

This block is a control state machine placed next to one serial receiver channel. It watches system events and decides which of three reset depths to issue, and when. The depths are a full receive reset, a PCS-only reset and an elastic-buffer reset. It also drives an automatic rate-change request when no loop-filter reprogramming is needed, and it asks the alignment logic to start again when the channel runs in buffer-bypass mode. A ready flag tells the rest of the datapath when the channel has come back from the last event.

Status inputs from the channel are brought into the control clock through two-flop synchronizers. The inputs treated this way are rate-done, user clock lock, recovered-clock stable, reset-done, connector plug-in, remote power-up, buffer overflow and buffer underflow. The rate-change request, its reconfiguration flag and the configuration-done handshake come from logic in the same clock and are used directly. The rising edge of each event is latched as a pending request, so an event that arrives while a sequence is running is served once that sequence has finished. When more than one request is pending they are served in a fixed priority order. A wait that lasts too long escalates to a full reset and sets a sticky error flag.

Top module: `rx_recovery_seq`

## Requirements
- R1: After reset, `ready_o` is 1 and all three reset pulses, `rate_strobe_o`, `align_req_o` and `err_o` are 0.
- R2: A rising edge on `plug_evt_i` or `remote_up_i` produces one `full_rst_o` pulse of exactly PULSE_LEN cycles. The block then waits for `reset_done_i` to go low and come back high. `ready_o` stays 0 from the start of the pulse until the recovery is complete.
- R3: In buffered mode (`bypass_i`=0), if the recovered clock is already stable when reset-done returns, no buffer reset is issued. If it is not yet stable, one `buf_rst_o` pulse of PULSE_LEN cycles follows once it becomes stable.
- R4: `align_req_o` is a single-cycle pulse. It is issued only in bypass mode (`bypass_i`=1), only after the recovered clock is seen stable, and once at the end of every recovery (full, PCS or rate change).
- R5: A `rate_req_i` with `rate_cfg_i`=0 gives one single-cycle `rate_strobe_o` and no reset pulse. The block then waits for `rate_done_i` before it is ready again.
- R6: A `rate_req_i` with `rate_cfg_i`=1 issues nothing until `cfg_done_i` is seen. It then runs the full reset recovery of R2 and R3.
- R7: A falling edge of `usr_lock_i` drops `ready_o` while lock stays low. When lock returns, one `pcs_rst_o` pulse of PULSE_LEN cycles is issued, never unless lock was high in the cycle before.
- R8: A rising edge of `buf_ovf_i` or `buf_unf_i` gives one `buf_rst_o` pulse of PULSE_LEN cycles.
- R9: Events are latched while a sequence runs and served afterwards in the order full-reset causes, lock-return PCS reset, rate change, buffer error. A latched request stays pending until it is served.
- R10: If a wait for configuration-done, reset-done, recovered clock or rate-done lasts TIMEOUT cycles, `err_o` is set and a full reset starts in the same cycle. `err_o` stays 1 until `rst_n`.
- R11: At most one of the three reset outputs is high in any cycle, and `ready_o` is 0 whenever any of them is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bypass_i | input | 1 | Strap: 1 = elastic buffer bypassed, alignment used |
| rate_req_i | input | 1 | Single-cycle rate-change request |
| rate_cfg_i | input | 1 | With rate_req_i: 1 = loop-filter reprogramming needed |
| cfg_done_i | input | 1 | Configuration writes have completed |
| rate_done_i | input | 1 | Channel reports rate change complete (asynchronous) |
| usr_lock_i | input | 1 | User clock source locked (asynchronous) |
| rclk_stable_i | input | 1 | Recovered clock stable (asynchronous) |
| reset_done_i | input | 1 | Channel receive reset complete (asynchronous) |
| plug_evt_i | input | 1 | Connector plug-in detect (asynchronous, edge used) |
| remote_up_i | input | 1 | Remote end powered up (asynchronous, edge used) |
| buf_ovf_i | input | 1 | Elastic buffer overflow (asynchronous, edge used) |
| buf_unf_i | input | 1 | Elastic buffer underflow (asynchronous, edge used) |
| full_rst_o | output | 1 | Full receive reset pulse |
| pcs_rst_o | output | 1 | PCS reset pulse |
| buf_rst_o | output | 1 | Elastic buffer reset pulse |
| rate_strobe_o | output | 1 | Automatic rate-change request strobe |
| align_req_o | output | 1 | Start alignment request |
| ready_o | output | 1 | Channel recovered and no request pending |
| err_o | output | 1 | Sticky timeout error |

## Verification
Each event kind is applied in both buffer modes. Full-reset causes are also applied with the recovered clock either already stable or still settling when reset-done returns. This separates the quiet ending from the buffer-reset ending and from the alignment ending. The rate change is tried with and without reconfiguration, which shows whether the strobe path and the reset path are chosen correctly. A busy period with several events injected at once exposes the priority order and the latching, and a rate-done that never arrives exposes the timeout escalation and the sticky error.

// File: rtl/rx_recovery_pkg.sv
package rx_recovery_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_WAIT_CFG, ST_FULL, ST_WAIT_RDONE, ST_WAIT_RCLK, ST_BUF,
    ST_PCS, ST_RATE, ST_WAIT_RATE, ST_WAIT_ALIGN, ST_ALIGN
  } seq_state_e;

  typedef enum logic [2:0] {SVC_NONE, SVC_FULL, SVC_PCS, SVC_RATE, SVC_BUF} svc_e;

  // bit positions in the synchronized status vector
  localparam int SI_RATE_DONE = 0;
  localparam int SI_LOCK      = 1;
  localparam int SI_RCLK      = 2;
  localparam int SI_RDONE     = 3;
  localparam int SI_PLUG      = 4;
  localparam int SI_PWR       = 5;
  localparam int SI_OVF       = 6;
  localparam int SI_UNF       = 7;
  localparam int SI_COUNT     = 8;

  // fixed service priority; a pending PCS reset blocks lower causes until lock returns
  function automatic svc_e pick_service(input logic full, input logic pcs, input logic lock,
                                        input logic rate, input logic bufe);
    if (full)      return SVC_FULL;
    if (pcs)       return lock ? SVC_PCS : SVC_NONE;
    if (rate)      return SVC_RATE;
    if (bufe)      return SVC_BUF;
    return SVC_NONE;
  endfunction

  function automatic seq_state_e after_recovery(input logic bypass);
    return bypass ? ST_WAIT_ALIGN : ST_IDLE;
  endfunction

  // last cycle of a window of len cycles counted from zero
  function automatic logic window_end(input logic [31:0] t, input int unsigned len);
    return t == 32'(len - 1);
  endfunction

endpackage

// File: rtl/rx_sync2.sv
module rx_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [1:0] stg;
    always_ff @(posedge clk) begin
      if (!rst_n) stg <= '0;
      else        stg <= {stg[0], d[i]};
    end
    assign q[i] = stg[1];
  end
endmodule

// File: rtl/rx_event_latch.sv
module rx_event_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic plug_s,
  input  logic pwr_s,
  input  logic ovf_s,
  input  logic unf_s,
  input  logic lock_s,
  input  logic rate_req_i,
  input  logic rate_cfg_i,
  input  logic clr_full,
  input  logic clr_pcs,
  input  logic clr_rate,
  input  logic clr_buf,
  output logic pend_full,
  output logic pend_pcs,
  output logic pend_rate,
  output logic pend_rate_cfg,
  output logic pend_buf
);
  logic [3:0] prev_evt;
  logic       prev_lock;
  logic       full_rise, buf_rise, lock_fall;

  assign full_rise = (plug_s & ~prev_evt[0]) | (pwr_s & ~prev_evt[1]);
  assign buf_rise  = (ovf_s & ~prev_evt[2]) | (unf_s & ~prev_evt[3]);
  assign lock_fall = prev_lock & ~lock_s;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_evt      <= '0;
      prev_lock     <= 1'b0;
      pend_full     <= 1'b0;
      pend_pcs      <= 1'b0;
      pend_rate     <= 1'b0;
      pend_rate_cfg <= 1'b0;
      pend_buf      <= 1'b0;
    end else begin
      prev_evt      <= {unf_s, ovf_s, pwr_s, plug_s};
      prev_lock     <= lock_s;
      pend_full     <= (pend_full & ~clr_full) | full_rise;
      pend_pcs      <= (pend_pcs & ~clr_pcs) | lock_fall;
      pend_rate     <= (pend_rate & ~clr_rate) | rate_req_i;
      pend_rate_cfg <= (pend_rate_cfg & ~clr_rate) | (rate_req_i & rate_cfg_i);
      pend_buf      <= (pend_buf & ~clr_buf) | buf_rise;
    end
  end

  assert_hold_buf_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pend_buf && !clr_buf |=> pend_buf);
  assert_hold_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pend_full && !clr_full |=> pend_full);
endmodule

// File: rtl/rx_recovery_seq.sv
module rx_recovery_seq
  import rx_recovery_pkg::*;
#(
  parameter int PULSE_LEN = 4,
  parameter int TIMEOUT   = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bypass_i,
  input  logic rate_req_i,
  input  logic rate_cfg_i,
  input  logic cfg_done_i,
  input  logic rate_done_i,
  input  logic usr_lock_i,
  input  logic rclk_stable_i,
  input  logic reset_done_i,
  input  logic plug_evt_i,
  input  logic remote_up_i,
  input  logic buf_ovf_i,
  input  logic buf_unf_i,
  output logic full_rst_o,
  output logic pcs_rst_o,
  output logic buf_rst_o,
  output logic rate_strobe_o,
  output logic align_req_o,
  output logic ready_o,
  output logic err_o
);
  localparam int SPAN = (TIMEOUT > PULSE_LEN) ? TIMEOUT : PULSE_LEN;
  localparam int TW   = $clog2(SPAN + 1);

  logic [SI_COUNT-1:0] raw_s, sync_s;
  logic rate_done_s, lock_s, rclk_s, rdone_s;
  logic pend_full, pend_pcs, pend_rate, pend_rate_cfg, pend_buf;
  logic clr_full, clr_pcs, clr_rate, clr_buf;
  seq_state_e st, nxt;
  logic [TW-1:0] tmr;
  logic armed, waiting, expire, set_err;
  svc_e svc;

  assign raw_s[SI_RATE_DONE] = rate_done_i;
  assign raw_s[SI_LOCK]      = usr_lock_i;
  assign raw_s[SI_RCLK]      = rclk_stable_i;
  assign raw_s[SI_RDONE]     = reset_done_i;
  assign raw_s[SI_PLUG]      = plug_evt_i;
  assign raw_s[SI_PWR]       = remote_up_i;
  assign raw_s[SI_OVF]       = buf_ovf_i;
  assign raw_s[SI_UNF]       = buf_unf_i;

  rx_sync2 #(.W(SI_COUNT)) u_sync (.clk(clk), .rst_n(rst_n), .d(raw_s), .q(sync_s));

  assign rate_done_s = sync_s[SI_RATE_DONE];
  assign lock_s      = sync_s[SI_LOCK];
  assign rclk_s      = sync_s[SI_RCLK];
  assign rdone_s     = sync_s[SI_RDONE];

  rx_event_latch u_evt (
    .clk(clk), .rst_n(rst_n),
    .plug_s(sync_s[SI_PLUG]), .pwr_s(sync_s[SI_PWR]),
    .ovf_s(sync_s[SI_OVF]), .unf_s(sync_s[SI_UNF]), .lock_s(lock_s),
    .rate_req_i(rate_req_i), .rate_cfg_i(rate_cfg_i),
    .clr_full(clr_full), .clr_pcs(clr_pcs), .clr_rate(clr_rate), .clr_buf(clr_buf),
    .pend_full(pend_full), .pend_pcs(pend_pcs), .pend_rate(pend_rate),
    .pend_rate_cfg(pend_rate_cfg), .pend_buf(pend_buf)
  );

  assign svc     = pick_service(pend_full, pend_pcs, lock_s, pend_rate, pend_buf);
  assign waiting = st inside {ST_WAIT_CFG, ST_WAIT_RDONE, ST_WAIT_RCLK, ST_WAIT_RATE, ST_WAIT_ALIGN};
  assign expire  = waiting && window_end(32'(tmr), TIMEOUT);

  always_comb begin
    nxt      = st;
    set_err  = 1'b0;
    clr_pcs  = 1'b0;
    clr_rate = 1'b0;
    clr_buf  = 1'b0;
    unique case (st)
      ST_IDLE: begin
        unique case (svc)
          SVC_FULL: nxt = ST_FULL;
          SVC_PCS:  begin nxt = ST_PCS; clr_pcs = 1'b1; end
          SVC_RATE: begin nxt = pend_rate_cfg ? ST_WAIT_CFG : ST_RATE; clr_rate = 1'b1; end
          SVC_BUF:  begin nxt = ST_BUF; clr_buf = 1'b1; end
          default:  nxt = ST_IDLE;
        endcase
      end
      ST_WAIT_CFG:   if (cfg_done_i) nxt = ST_FULL;
      ST_FULL:       if (window_end(32'(tmr), PULSE_LEN)) nxt = ST_WAIT_RDONE;
      ST_WAIT_RDONE: if (armed && rdone_s) nxt = rclk_s ? after_recovery(bypass_i) : ST_WAIT_RCLK;
      ST_WAIT_RCLK:  if (rclk_s) nxt = bypass_i ? ST_WAIT_ALIGN : ST_BUF;
      ST_BUF:        if (window_end(32'(tmr), PULSE_LEN)) nxt = ST_IDLE;
      ST_PCS:        if (window_end(32'(tmr), PULSE_LEN)) nxt = after_recovery(bypass_i);
      ST_RATE:       nxt = ST_WAIT_RATE;
      ST_WAIT_RATE:  if (rate_done_s) nxt = after_recovery(bypass_i);
      ST_WAIT_ALIGN: if (rclk_s) nxt = ST_ALIGN;
      ST_ALIGN:      nxt = ST_IDLE;
      default:       nxt = ST_IDLE;
    endcase
    if (expire && nxt == st) begin
      nxt     = ST_FULL;
      set_err = 1'b1;
    end
    clr_full = (nxt == ST_FULL) && (st != ST_FULL);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      tmr   <= '0;
      armed <= 1'b0;
      err_o <= 1'b0;
    end else begin
      st    <= nxt;
      tmr   <= (nxt != st || st == ST_IDLE) ? '0 : tmr + 1'b1;
      if (clr_full)                                               armed <= 1'b0;
      else if ((st == ST_FULL || st == ST_WAIT_RDONE) && !rdone_s) armed <= 1'b1;
      if (set_err) err_o <= 1'b1;
    end
  end

  assign full_rst_o    = (st == ST_FULL);
  assign pcs_rst_o     = (st == ST_PCS);
  assign buf_rst_o     = (st == ST_BUF);
  assign rate_strobe_o = (st == ST_RATE);
  assign align_req_o   = (st == ST_ALIGN);
  assign ready_o       = (st == ST_IDLE) && !(pend_full | pend_pcs | pend_rate | pend_buf);

  assert_one_reset_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({full_rst_o, pcs_rst_o, buf_rst_o}));
  assert_busy_in_reset_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (full_rst_o || pcs_rst_o || buf_rst_o) |-> !ready_o);
  assert_align_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
    align_req_o |-> bypass_i && $past(rclk_s));
  assert_align_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    align_req_o |=> !align_req_o);
  assert_strobe_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rate_strobe_o |=> !rate_strobe_o && !full_rst_o);
  assert_pcs_after_lock_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pcs_rst_o) |-> $past(lock_s));
  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> err_o);
  assert_err_escalates_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_o) |-> full_rst_o);
endmodule

// File: tb/rx_recovery_seq_test.sv
module rx_recovery_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int PULSE      = 4;
  localparam int TMO        = 300;
  localparam int RD_LAT     = 10;
  localparam int RC_LAT     = 15;
  localparam int RA_LAT     = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bypass = 1'b0, rate_req = 1'b0, rate_cfg = 1'b0, cfg_done = 1'b0;
  logic usr_lock = 1'b1, plug = 1'b0, pwr = 1'b0, ovf = 1'b0, unf = 1'b0;
  logic rdone = 1'b1, rclk = 1'b1, rate_done = 1'b0;
  logic full_rst, pcs_rst, buf_rst, rate_strobe, align_req, ready, err;

  logic late_mode = 1'b0, rate_en = 1'b1;
  int rd_cnt = 0, rc_cnt = 0, ra_cnt = 0;

  int n_tests = 0, n_fail = 0;
  int tot_full = 0, tot_pcs = 0, tot_buf = 0, tot_strobe = 0, tot_align = 0, overlap = 0;
  int run_full = 0, run_pcs = 0, run_buf = 0, len_full = 0, len_pcs = 0, len_buf = 0;
  int log_code [64];
  int log_n = 0;
  logic pf = 0, pp = 0, pb = 0, ps = 0, pa = 0;

  rx_recovery_seq #(.PULSE_LEN(PULSE), .TIMEOUT(TMO)) uut (
    .clk(clk), .rst_n(rst_n), .bypass_i(bypass), .rate_req_i(rate_req), .rate_cfg_i(rate_cfg),
    .cfg_done_i(cfg_done), .rate_done_i(rate_done), .usr_lock_i(usr_lock),
    .rclk_stable_i(rclk), .reset_done_i(rdone), .plug_evt_i(plug), .remote_up_i(pwr),
    .buf_ovf_i(ovf), .buf_unf_i(unf), .full_rst_o(full_rst), .pcs_rst_o(pcs_rst),
    .buf_rst_o(buf_rst), .rate_strobe_o(rate_strobe), .align_req_o(align_req),
    .ready_o(ready), .err_o(err)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  // channel model: reset-done, recovered clock and rate-done responses
  always @(negedge clk) begin
    if (full_rst) begin
      rdone <= 1'b0; rd_cnt <= 0;
      if (late_mode) begin rclk <= 1'b0; rc_cnt <= 0; end
    end else if (!rdone) begin
      if (rd_cnt == RD_LAT) rdone <= 1'b1; else rd_cnt <= rd_cnt + 1;
    end else if (!rclk) begin
      if (rc_cnt == RC_LAT) rclk <= 1'b1; else rc_cnt <= rc_cnt + 1;
    end
    if (rate_strobe && rate_en) ra_cnt <= 1;
    else if (ra_cnt != 0) begin
      ra_cnt <= ra_cnt + 1;
      if (ra_cnt == RA_LAT) rate_done <= 1'b1;
      if (ra_cnt == RA_LAT + 4) begin rate_done <= 1'b0; ra_cnt <= 0; end
    end
  end

  // output monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (full_rst) run_full++; else if (run_full != 0) begin len_full = run_full; run_full = 0; end
      if (pcs_rst)  run_pcs++;  else if (run_pcs != 0)  begin len_pcs = run_pcs; run_pcs = 0; end
      if (buf_rst)  run_buf++;  else if (run_buf != 0)  begin len_buf = run_buf; run_buf = 0; end
      if (full_rst && !pf)    begin tot_full++;   if (log_n < 64) log_code[log_n] = 1; log_n++; end
      if (pcs_rst && !pp)     begin tot_pcs++;    if (log_n < 64) log_code[log_n] = 2; log_n++; end
      if (buf_rst && !pb)     begin tot_buf++;    if (log_n < 64) log_code[log_n] = 3; log_n++; end
      if (rate_strobe && !ps) begin tot_strobe++; if (log_n < 64) log_code[log_n] = 4; log_n++; end
      if (align_req && !pa)   begin tot_align++;  if (log_n < 64) log_code[log_n] = 5; log_n++; end
      if ((int'(full_rst) + int'(pcs_rst) + int'(buf_rst)) > 1 ||
          (ready && (full_rst || pcs_rst || buf_rst))) overlap++;
      pf = full_rst; pp = pcs_rst; pb = buf_rst; ps = rate_strobe; pa = align_req;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pulse_in(input int kind);
    @(negedge clk);
    case (kind)
      0: plug = 1'b1;
      1: pwr  = 1'b1;
      5: ovf  = 1'b1;
      default: unf = 1'b1;
    endcase
    repeat (3) @(negedge clk);
    plug = 1'b0; pwr = 1'b0; ovf = 1'b0; unf = 1'b0;
  endtask

  task automatic rate_in(input logic cfg);
    @(negedge clk);
    rate_req = 1'b1; rate_cfg = cfg;
    @(negedge clk);
    rate_req = 1'b0; rate_cfg = 1'b0;
  endtask

  task automatic wait_recovered();
    for (int i = 0; i < 40 && ready; i++) @(negedge clk);
    for (int i = 0; i < 2000 && !ready; i++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  function automatic string req_of(input int kind);
    case (kind)
      0, 1: return "R2";
      2:    return "R5";
      3:    return "R6";
      4:    return "R7";
      default: return "R8";
    endcase
  endfunction

  // {bypass, kind[2:0], late, exp_full, exp_pcs, exp_buf, exp_strobe, exp_align}
  // kind: 0 plug-in, 1 remote power-up, 2 rate, 3 rate with reconfig, 4 lock loss, 5 overflow, 6 underflow
  localparam logic [9:0] VECS [12] = '{
    10'b0_000_0_10000, 10'b0_001_1_10100, 10'b1_000_0_10001, 10'b1_001_1_10001,
    10'b0_010_0_00010, 10'b1_010_0_00011, 10'b0_011_0_10000, 10'b1_011_1_10001,
    10'b0_100_0_01000, 10'b1_100_0_01001, 10'b0_101_0_00100, 10'b1_110_0_00100
  };

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog (all requirements) actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    // R1: reset state
    check("R1 ready", int'(ready), 1);
    check("R1 resets", int'(full_rst | pcs_rst | buf_rst), 0);
    check("R1 strobe/align", int'(rate_strobe | align_req), 0);
    check("R1 err", int'(err), 0);

    foreach (VECS[v]) begin
      automatic logic [9:0] e = VECS[v];
      automatic int kind = int'(e[8:6]);
      automatic int b_full = tot_full, b_pcs = tot_pcs, b_buf = tot_buf;
      automatic int b_str = tot_strobe, b_al = tot_align;
      automatic string rq = req_of(kind);
      bypass = e[9]; late_mode = e[5];
      repeat (3) @(negedge clk);
      case (kind)
        2: rate_in(1'b0);
        3: begin
          rate_in(1'b1);
          repeat (20) @(negedge clk);
          check($sformatf("vec%0d R6 no reset before cfg done", v), tot_full - b_full, 0);
          @(negedge clk); cfg_done = 1'b1; @(negedge clk); cfg_done = 1'b0;
        end
        4: begin
          @(negedge clk); usr_lock = 1'b0;
          repeat (8) @(negedge clk);
          check($sformatf("vec%0d R7 ready low without lock", v), int'(ready), 0);
          check($sformatf("vec%0d R7 no pcs before relock", v), tot_pcs - b_pcs, 0);
          usr_lock = 1'b1;
        end
        default: pulse_in(kind);
      endcase
      wait_recovered();
      check($sformatf("vec%0d %s full count", v, rq), tot_full - b_full, int'(e[4]));
      check($sformatf("vec%0d %s pcs count", v, rq), tot_pcs - b_pcs, int'(e[3]));
      check($sformatf("vec%0d R3 R8 buf count", v), tot_buf - b_buf, int'(e[2]));
      check($sformatf("vec%0d %s strobe count", v, rq), tot_str_delta(b_str), int'(e[1]));
      check($sformatf("vec%0d R4 align count", v), tot_align - b_al, int'(e[0]));
      if (e[4]) check($sformatf("vec%0d R2 full width", v), len_full, PULSE);
      if (e[3]) check($sformatf("vec%0d R7 pcs width", v), len_pcs, PULSE);
      if (e[2]) check($sformatf("vec%0d R8 buf width", v), len_buf, PULSE);
      check($sformatf("vec%0d %s ready after", v, rq), int'(ready), 1);
    end

    // R9: events during a busy sequence, served in priority order
    begin
      automatic int start = log_n;
      bypass = 1'b0; late_mode = 1'b0;
      pulse_in(0);
      for (int i = 0; i < 20 && !full_rst; i++) @(negedge clk);
      @(negedge clk); ovf = 1'b1; rate_req = 1'b1;
      @(negedge clk); rate_req = 1'b0; plug = 1'b1;
      repeat (3) @(negedge clk); ovf = 1'b0; plug = 1'b0;
      wait_recovered();
      check("R9 event count", log_n - start, 4);
      check("R9 first full", log_code[start], 1);
      check("R9 latched full second", log_code[start + 1], 1);
      check("R9 rate third", log_code[start + 2], 4);
      check("R9 buffer last", log_code[start + 3], 3);
    end

    // R10: rate-done never returns
    begin
      automatic int b_full = tot_full;
      rate_en = 1'b0;
      rate_in(1'b0);
      for (int i = 0; i < TMO + 100 && !err; i++) @(negedge clk);
      check("R10 err set on timeout", int'(err), 1);
      check("R10 full reset on timeout", int'(full_rst), 1);
      rate_en = 1'b1;
      wait_recovered();
      check("R10 one escalation", tot_full - b_full, 1);
      check("R10 err sticky", int'(err), 1);
    end

    check("R11 no overlap", overlap, 0);
    summary();
    $finish;
  end

  function automatic int tot_str_delta(input int base);
    return tot_strobe - base;
  endfunction
endmodule